// File: doc/BRIEF.md
# Sixteen-Line Latching Interrupt Controller

This block collects sixteen interrupt request lines into one processor's private peripheral bus and presents them as two request outputs: a normal interrupt (IRQ) and a fast interrupt (FIQ). Each line has its own sensitivity bit and its own routing bit. The sensitivity bit selects edge or level detection. The routing bit selects the output the line is delivered to. Each line also has a mask bit. A pending register records which sources have fired. Edge-sensitive bits are latched until software clears them. Level-sensitive bits follow the synchronized line.

Each output has its own three-state sequencer. In `OS_IDLE` the sequencer evaluates the unmasked pending sources routed to that output. The lowest-numbered source wins. On the capture transition (`OS_IDLE -> OS_ACTIVE`) the sequencer raises the output and freezes that source's number in the identification register.

Reading the identification register takes the service transition (`OS_ACTIVE -> OS_SERVICED`). For an edge source, that read also clears the pending bit.

Writing the control register asks for the release transition (`OS_ACTIVE` or `OS_SERVICED` -> `OS_IDLE`). The release happens only if the serviced source's pending bit is already clear or masked. Otherwise the sequencer keeps its state and the output stays high.

Top module: `intc16_latch`

## Requirements
- R1: After reset the pending register (address 0) reads 0x0000, the mask register (address 1) reads 0xFFFF, the sensitivity (address 2) and routing (address 3) registers read 0x0000, both identification registers read 0x0000, and both outputs are low.
- R2: On an input whose sensitivity bit is 0 (edge mode), a rising edge sets bit n of the pending register for input n. The bit stays set after the line falls, until it is cleared.
- R3: A write to address 0 clears each edge-mode pending bit whose data bit is 0 and leaves the bit unchanged where the data bit is 1. Level-mode bits are unaffected. If a rising edge and a clear land in the same cycle, the bit ends up set.
- R4: A read of address 4 (IRQ identification) or address 5 (FIQ identification) while that register is valid clears the pending bit of the reported source if the source is in edge mode. A level-mode bit is left alone.
- R5: With its sensitivity bit at 1 (level mode), a pending bit follows the synchronized line and clears only when the line goes low.
- R6: A mask bit of 1 blocks delivery of that source. The pending bit is still recorded.
- R7: A source whose pending bit is cleared while it is masked is not delivered when it is later unmasked.
- R8: A write to address 6 with data bit 0 set re-arms IRQ, and with data bit 1 set re-arms FIQ. The output and its identification register release only if the serviced source's pending bit is clear or its mask bit is 1 at that write. Otherwise the output stays asserted with the same identification.
- R9: Once asserted, an output stays high and its identification register stays unchanged until a release.
- R10: Among unmasked pending sources routed to one output, the lowest-numbered one is reported. The identification value carries the valid flag in bit 15 and the source number in bits 3:0, with all other bits 0.
- R11: A routing bit of 1 sends the source to FIQ and a routing bit of 0 sends it to IRQ. When both outputs are idle and both gain a candidate in the same cycle, FIQ asserts one cycle before IRQ.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_lines | input | 16 | Interrupt request lines, asynchronous, active high |
| bus_addr | input | 3 | Register address |
| bus_rd | input | 1 | Read strobe; read side effects take place at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register, combinational |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The hardest case to reach is a rising edge on a line that lands in exactly the same clock as a write that clears the pending bit. The bench counts the three register stages between the pin and the pending bit, so it issues the write strobe so that both events fall on the same edge. A second hard case is a re-arm that must be refused: a level line still high, or an edge bit never read. The bench builds it by issuing the control write before clearing the cause, then checks that the output and its identification stay unchanged.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    typedef enum logic [1:0] {
        OS_IDLE     = 2'd0,
        OS_ACTIVE   = 2'd1,
        OS_SERVICED = 2'd2
    } out_state_e;

    localparam logic [2:0] ADR_PEND   = 3'd0;
    localparam logic [2:0] ADR_MASK   = 3'd1;
    localparam logic [2:0] ADR_SENS   = 3'd2;
    localparam logic [2:0] ADR_ROUTE  = 3'd3;
    localparam logic [2:0] ADR_IRQ_ID = 3'd4;
    localparam logic [2:0] ADR_FIQ_ID = 3'd5;
    localparam logic [2:0] ADR_CTRL   = 3'd6;

    localparam int OUT_IRQ = 0;
    localparam int OUT_FIQ = 1;
    localparam int NUM_OUT = 2;

endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
    parameter int N      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] line_i,
    output logic [N-1:0] level_o,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] chain_q [STAGES];
    logic [N-1:0] prev_q;

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= line_i;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[s] <= '0;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/irqc_pending.sv
module irqc_pending #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sens_i,
    input  logic [N-1:0] rise_i,
    input  logic [N-1:0] level_i,
    input  logic         wr_clr_i,
    input  logic [N-1:0] wr_data_i,
    input  logic [N-1:0] id_clr_i,
    output logic [N-1:0] pend_o
);
    logic [N-1:0] pend_q;

    genvar i;
    generate
        for (i = 0; i < N; i++) begin : g_bit
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    pend_q[i] <= 1'b0;
                end else if (sens_i[i]) begin
                    pend_q[i] <= level_i[i];
                end else if (rise_i[i]) begin
                    pend_q[i] <= 1'b1;
                end else if ((wr_clr_i && !wr_data_i[i]) || id_clr_i[i]) begin
                    pend_q[i] <= 1'b0;
                end
            end
        end
    endgenerate

    assign pend_o = pend_q;

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((pend_q & $past(sens_i)) == ($past(level_i) & $past(sens_i)))) // R5
        else $error("level pending bit does not follow its line");

    AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~$past(sens_i) & $past(rise_i) & ~pend_q) == '0)) // R3
        else $error("edge lost against a clear");

endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
    parameter int N   = 16,
    parameter int IDW = $clog2(N)
) (
    input  logic [N-1:0]   req_i,
    output logic           valid_o,
    output logic [IDW-1:0] id_o
);
    always_comb begin
        valid_o = 1'b0;
        id_o    = '0;
        for (int k = N - 1; k >= 0; k--) begin
            if (req_i[k]) begin
                valid_o = 1'b1;
                id_o    = IDW'(k);
            end
        end
    end
endmodule

// File: rtl/irqc_out_fsm.sv
module irqc_out_fsm
    import irqc_pkg::*;
#(
    parameter int N   = 16,
    parameter int IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cand_valid_i,
    input  logic [IDW-1:0] cand_id_i,
    input  logic           allow_i,
    input  logic           rearm_i,
    input  logic           id_read_i,
    input  logic [N-1:0]   pend_i,
    input  logic [N-1:0]   mask_i,
    output logic           out_o,
    output logic           valid_o,
    output logic [IDW-1:0] id_o,
    output logic           capture_o
);
    out_state_e     state_q, state_d;
    logic [IDW-1:0] id_q;
    logic           released;

    assign released  = !pend_i[id_q] || mask_i[id_q];
    assign capture_o = (state_q == OS_IDLE) && cand_valid_i && allow_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= OS_IDLE;
            id_q    <= '0;
        end else begin
            state_q <= state_d;
            if (capture_o) id_q <= cand_id_i;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            OS_IDLE: begin
                if (cand_valid_i && allow_i) state_d = OS_ACTIVE;
            end
            OS_ACTIVE: begin
                if (rearm_i && released) state_d = OS_IDLE;
                else if (id_read_i)      state_d = OS_SERVICED;
            end
            OS_SERVICED: begin
                if (rearm_i && released) state_d = OS_IDLE;
            end
            default: state_d = OS_IDLE;
        endcase
    end

    always_comb begin
        out_o   = (state_q != OS_IDLE);
        valid_o = (state_q != OS_IDLE);
        id_o    = id_q;
    end

    AST_HOLD_UNTIL_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        out_o && !rearm_i |=> out_o) // R9
        else $error("output dropped without re-arm");

    AST_ID_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_o |=> (!out_o || $stable(id_o))) // R9
        else $error("identification changed while asserted");

    AST_RELEASE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_o) |-> ($past(rearm_i) && !($past(pend_i[id_q]) && !$past(mask_i[id_q])))) // R8
        else $error("released while serviced source still pending");

endmodule

// File: rtl/intc16_latch.sv
module intc16_latch
    import irqc_pkg::*;
#(
    parameter int N      = 16,
    parameter int DATA_W = 16,
    parameter int SYNC   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N-1:0]      req_lines,
    input  logic [2:0]        bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_out,
    output logic              fiq_out
);
    localparam int IDW = $clog2(N);

    logic [N-1:0]   mask_q, sens_q, route_q;
    logic [N-1:0]   level_s, rise_s, pend;
    logic [N-1:0]   id_clr;
    logic [N-1:0]   cand_req   [NUM_OUT];
    logic           cand_valid [NUM_OUT];
    logic [IDW-1:0] cand_id    [NUM_OUT];
    logic           allow      [NUM_OUT];
    logic           rearm      [NUM_OUT];
    logic           id_rd      [NUM_OUT];
    logic           out_v      [NUM_OUT];
    logic           id_valid   [NUM_OUT];
    logic [IDW-1:0] id_num     [NUM_OUT];
    logic           capture    [NUM_OUT];
    logic           wr_pend;

    irqc_sync #(.N(N), .STAGES(SYNC)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (req_lines),
        .level_o (level_s),
        .rise_o  (rise_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q  <= '1;
            sens_q  <= '0;
            route_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADR_MASK)  mask_q  <= bus_wdata[N-1:0];
            if (bus_addr == ADR_SENS)  sens_q  <= bus_wdata[N-1:0];
            if (bus_addr == ADR_ROUTE) route_q <= bus_wdata[N-1:0];
        end
    end

    assign wr_pend = bus_wr && (bus_addr == ADR_PEND);

    always_comb begin
        id_clr = '0;
        for (int g = 0; g < NUM_OUT; g++) begin
            if (id_rd[g] && id_valid[g]) id_clr[id_num[g]] = 1'b1;
        end
    end

    irqc_pending #(.N(N)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .sens_i    (sens_q),
        .rise_i    (rise_s),
        .level_i   (level_s),
        .wr_clr_i  (wr_pend),
        .wr_data_i (bus_wdata[N-1:0]),
        .id_clr_i  (id_clr),
        .pend_o    (pend)
    );

    genvar g;
    generate
        for (g = 0; g < NUM_OUT; g++) begin : g_out
            if (g == OUT_FIQ) begin : g_fiq
                assign cand_req[g] = pend & ~mask_q & route_q;
                assign allow[g]    = 1'b1;
                assign id_rd[g]    = bus_rd && (bus_addr == ADR_FIQ_ID);
            end else begin : g_irq
                assign cand_req[g] = pend & ~mask_q & ~route_q;
                assign allow[g]    = !capture[OUT_FIQ];
                assign id_rd[g]    = bus_rd && (bus_addr == ADR_IRQ_ID);
            end
            assign rearm[g] = bus_wr && (bus_addr == ADR_CTRL) && bus_wdata[g];

            irqc_arbiter #(.N(N), .IDW(IDW)) u_arb (
                .req_i   (cand_req[g]),
                .valid_o (cand_valid[g]),
                .id_o    (cand_id[g])
            );

            irqc_out_fsm #(.N(N), .IDW(IDW)) u_fsm (
                .clk          (clk),
                .rst_n        (rst_n),
                .cand_valid_i (cand_valid[g]),
                .cand_id_i    (cand_id[g]),
                .allow_i      (allow[g]),
                .rearm_i      (rearm[g]),
                .id_read_i    (id_rd[g]),
                .pend_i       (pend),
                .mask_i       (mask_q),
                .out_o        (out_v[g]),
                .valid_o      (id_valid[g]),
                .id_o         (id_num[g]),
                .capture_o    (capture[g])
            );
        end
    endgenerate

    function automatic logic [DATA_W-1:0] id_word(input logic v, input logic [IDW-1:0] n);
        logic [DATA_W-1:0] w;
        w = '0;
        if (v) begin
            w[DATA_W-1] = 1'b1;
            w[IDW-1:0]  = n;
        end
        return w;
    endfunction

    always_comb begin
        unique case (bus_addr)
            ADR_PEND:   bus_rdata = DATA_W'(pend);
            ADR_MASK:   bus_rdata = DATA_W'(mask_q);
            ADR_SENS:   bus_rdata = DATA_W'(sens_q);
            ADR_ROUTE:  bus_rdata = DATA_W'(route_q);
            ADR_IRQ_ID: bus_rdata = id_word(id_valid[OUT_IRQ], id_num[OUT_IRQ]);
            ADR_FIQ_ID: bus_rdata = id_word(id_valid[OUT_FIQ], id_num[OUT_FIQ]);
            default:    bus_rdata = '0;
        endcase
    end

    assign irq_out = out_v[OUT_IRQ];
    assign fiq_out = out_v[OUT_FIQ];

    AST_FIQ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> !$past(capture[OUT_FIQ])) // R11
        else $error("IRQ captured in the same cycle as FIQ");

endmodule

// File: tb/intc16_latch_test.sv
`timescale 1ns/100ps
module intc16_latch_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] lines = '0;
    logic [2:0]  addr = '0;
    logic        rd = 1'b0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq, fiq;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    string       tag_q[$];
    logic [15:0] exp_q[$];
    logic [15:0] act_q[$];

    always #2.5 clk = ~clk;

    intc16_latch uut (
        .clk(clk), .rst_n(rst_n), .req_lines(lines),
        .bus_addr(addr), .bus_rd(rd), .bus_wr(wr), .bus_wdata(wdata),
        .bus_rdata(rdata), .irq_out(irq), .fiq_out(fiq)
    );

    // driver side: push one expected item with its observed value
    task automatic push(input string tag, input logic [15:0] exp, input logic [15:0] act);
        tag_q.push_back(tag);
        exp_q.push_back(exp);
        act_q.push_back(act);
    endtask

    // monitor: pops and compares
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            string t;
            logic [15:0] e, a;
            t = tag_q.pop_front();
            e = exp_q.pop_front();
            a = act_q.pop_front();
            compared++;
            if (a !== e) begin
                mismatched++;
                $display("FAIL %s: actual 0x%04h expected 0x%04h", t, a, e);
            end
        end
    end

    task automatic bus_read(input logic [2:0] a, input string tag, input logic [15:0] exp);
        @(negedge clk);
        addr = a; rd = 1'b1;
        #1 push(tag, exp, rdata);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic check_out(input string tag, input logic [1:0] exp);
        @(negedge clk);
        #1 push(tag, {14'b0, exp}, {14'b0, fiq, irq});
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [15:0] m);
        @(negedge clk);
        lines = lines | m;
        idle(2);
        lines = lines & ~m;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(3'd0, "R1 pending", 16'h0000);
        bus_read(3'd1, "R1 mask", 16'hFFFF);
        bus_read(3'd2, "R1 sens", 16'h0000);
        bus_read(3'd3, "R1 route", 16'h0000);
        bus_read(3'd4, "R1 irq id", 16'h0000);
        bus_read(3'd5, "R1 fiq id", 16'h0000);
        check_out("R1 outputs", 2'b00);

        // R2 / R6: edge latched while masked, no delivery
        pulse(16'h0008);
        idle(6);
        bus_read(3'd0, "R2 edge latched", 16'h0008);
        check_out("R6 masked silent", 2'b00);

        // R3 / R7: clear by writing zero, then unmask
        bus_write(3'd0, 16'hFFF7);
        bus_read(3'd0, "R3 write zero clears", 16'h0000);
        bus_write(3'd1, 16'hFF00);
        idle(3);
        check_out("R7 cleared then unmasked", 2'b00);

        // R10 priority, R4 clear on id read, R9 frozen, R8 re-arm
        pulse(16'h0024);
        idle(6);
        check_out("R10 irq asserted", 2'b01);
        bus_read(3'd4, "R10 lowest wins", 16'h8002);
        bus_read(3'd0, "R4 id read clears edge bit", 16'h0020);
        bus_read(3'd4, "R9 id frozen", 16'h8002);
        check_out("R9 output held", 2'b01);
        bus_write(3'd6, 16'h0001);
        idle(3);
        bus_read(3'd4, "R8 next source after re-arm", 16'h8005);
        bus_write(3'd6, 16'h0001);
        idle(2);
        check_out("R8 released", 2'b00);
        bus_read(3'd0, "R4 pending empty", 16'h0000);

        // R8 refused re-arm while edge bit pending, release by masking
        pulse(16'h0002);
        idle(6);
        bus_write(3'd6, 16'h0001);
        idle(2);
        check_out("R8 refused re-arm", 2'b01);
        bus_read(3'd4, "R8 id kept", 16'h8001);
        bus_write(3'd1, 16'hFF02);
        bus_write(3'd6, 16'h0001);
        idle(2);
        check_out("R8 release by mask", 2'b00);
        bus_write(3'd0, 16'hFFFD);
        bus_write(3'd1, 16'hFF00);

        // R5 level sensitivity
        bus_write(3'd2, 16'h0010);
        @(negedge clk);
        lines[4] = 1'b1;
        idle(6);
        bus_read(3'd0, "R5 level pending", 16'h0010);
        bus_read(3'd4, "R5 level id", 16'h8004);
        bus_read(3'd0, "R4 level not cleared by id read", 16'h0010);
        bus_write(3'd0, 16'h0000);
        bus_read(3'd0, "R3 level ignores write", 16'h0010);
        bus_write(3'd6, 16'h0001);
        idle(2);
        check_out("R8 level still high refused", 2'b01);
        @(negedge clk);
        lines[4] = 1'b0;
        idle(6);
        bus_read(3'd0, "R5 level cleared on drop", 16'h0000);
        check_out("R9 held after drop", 2'b01);
        bus_write(3'd6, 16'h0001);
        idle(2);
        check_out("R8 level released", 2'b00);
        bus_write(3'd2, 16'h0000);

        // R11 FIQ routing and preference
        bus_write(3'd3, 16'h0040);
        pulse(16'h00C0);
        begin
            int n = 0;
            while (!(irq || fiq) && n < 20) begin
                @(negedge clk);
                #1 n++;
            end
        end
        push("R11 fiq first", 16'h0002, {14'b0, fiq, irq});
        check_out("R11 irq next cycle", 2'b11);
        bus_read(3'd5, "R11 fiq id", 16'h8006);
        bus_read(3'd4, "R11 irq id", 16'h8007);
        bus_write(3'd6, 16'h0003);
        idle(2);
        check_out("R11 both released", 2'b00);
        bus_write(3'd3, 16'h0000);

        // R3 edge in the same cycle as a clear
        bus_write(3'd1, 16'hFFFF);
        @(negedge clk);
        lines[0] = 1'b1;
        @(negedge clk);
        bus_write(3'd0, 16'h0000);
        lines[0] = 1'b0;
        bus_read(3'd0, "R3 edge wins over clear", 16'h0001);
        bus_write(3'd0, 16'h0000);
        bus_read(3'd0, "R3 cleared afterwards", 16'h0000);

        idle(3);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule